// File: doc/BRIEF.md
# Byte/Word ALU with Flags

This block is the integer execution slice of a small 16-bit datapath. Each cycle it can accept one operation with two operands: a destination value and a source value. It also takes an operation code, a byte-or-word width select and the current six-bit status word. It computes the result and the new status word. One clock later it presents the result, a write-back strike and the new status word. It covers addition and subtraction with and without an incoming carry, increment, decrement, negation, the three bitwise operations, inversion, and the two flag-only comparisons (compare and test). Each class of operation changes only its own set of status bits.

Operands arrive on a plain valid strobe. The pipeline has one stage and no stall, so the block never applies back-pressure. A transaction is accepted on every clock edge where `in_valid` is high. Its outcome appears on the outputs during the following cycle, marked by `out_valid`. Between transactions the result and status outputs keep their last values. The caller holds the status register. It feeds that register in through `in_flags` and stores `out_flags` back when `out_valid` is high.

Top module: `bw_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_wr`, `out_result` and `out_flags` are all zero.
- R2: An operation accepted with `in_valid` high at a clock edge appears on the outputs after that edge, with `out_valid` high for exactly that one cycle. Back-to-back operations are accepted on consecutive edges, and `out_wr` is never high without `out_valid`.
- R3: When `in_byte` is 1, only the low 8 bits of each operand are used. The upper 8 result bits are zero, and carry, overflow, sign and zero are taken at the 8-bit width. When `in_byte` is 0, the full 16 bits are used.
- R4: Operation 0 (add) gives dst+src. Operation 1 (add with carry) gives dst+src+C. Both set carry (status bit 0) to the carry out of the selected width.
- R5: Operation 2 (subtract) gives dst-src. Operation 3 (subtract with borrow) gives dst-src-C. Both set carry to the borrow out of the selected width.
- R6: For the arithmetic operations, auxiliary (status bit 2) is the carry or borrow passed from bit 3 into bit 4.
- R7: For the arithmetic operations, overflow (status bit 5) is set when the signed result does not fit the selected width.
- R8: Every operation that updates flags sets parity (status bit 1) to 1 when the low 8 result bits hold an even number of ones. It sets zero (status bit 3) when the result at the selected width is zero, and sign (status bit 4) to the top bit at the selected width.
- R9: Operation 4 (increment) gives dst+1 and operation 5 (decrement) gives dst-1. Both update auxiliary, overflow, parity, sign and zero, but pass carry through unchanged from `in_flags`.
- R10: Operations 6 (AND), 7 (OR) and 8 (XOR) write the bitwise result, clear carry and overflow, update parity, sign and zero, and pass auxiliary through unchanged.
- R11: Operation 9 (invert) writes the ones' complement of dst at the selected width and leaves all six status bits equal to `in_flags`.
- R12: Operation 10 (negate) writes the two's complement of dst and updates all six status bits. Carry is set unless dst is zero at the selected width. src is ignored.
- R13: Operation 11 (compare) updates the status bits exactly as subtract does, and operation 12 (test) exactly as AND does. Neither raises `out_wr`. Compare sets zero for equal operands and sets carry exactly when dst is below src as unsigned numbers.
- R14: Operation codes 13 to 15 are reserved. They do not raise `out_wr`, and `out_flags` equals `in_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code (0..12, 13..15 reserved) |
| in_byte | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| in_dst | input | 16 | Destination operand |
| in_src | input | 16 | Source operand |
| in_flags | input | 6 | Current status: {overflow, sign, zero, aux, parity, carry} |
| out_valid | output | 1 | Outcome of the previous cycle's operation is present |
| out_result | output | 16 | Computed result |
| out_wr | output | 1 | Result should be written back |
| out_flags | output | 6 | New status word, same layout as `in_flags` |

## Verification
On every cycle, assertions check several rules that each relate an accepted operation to the following output cycle:
- increment and decrement keep carry;
- the bitwise operations clear carry and overflow and keep auxiliary;
- inversion keeps all six status bits;
- compare and test never request a write;
- byte operations leave the upper result half at zero;
- negate carries exactly when its operand is non-zero;
- a write is never requested without valid.

Only the directed scenarios can show that the arithmetic values are right: sums, differences, borrows, half-carries, signed overflow and parity. The scenarios also cover cases such as 0xFF+1 wrapping at byte width, negating 0x80, and two operations issued on consecutive edges.

// File: rtl/bwalu_pkg.sv
package bwalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_NOT  = 4'd9,
    OP_NEG  = 4'd10,
    OP_CMP  = 4'd11,
    OP_TEST = 4'd12
  } alu_op_e;

  // packed with carry in bit 0, overflow in bit 5
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } alu_flags_t;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_INV
  } logic_sel_e;

  typedef enum logic [1:0] {
    FC_HOLD,   // no status change
    FC_ARITH,  // all six bits
    FC_KEEPC,  // all but carry
    FC_LOGIC   // carry/ovf cleared, aux kept
  } flag_class_e;

endpackage

// File: rtl/bwalu_addsub.sv
module bwalu_addsub #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  input  logic         narrow_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         aux_o,
  output logic         ovf_o
);
  localparam int MSB  = W - 1;
  localparam int NMSB = NW - 1;
  localparam int HB   = 4;

  logic [W-1:0] mask, a_m, b_m, b_eff;
  logic [W:0]   raw;
  logic         cin_eff, cout, c_half, a_top, b_top, s_top;

  always_comb begin
    mask    = narrow_i ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
    a_m     = a_i & mask;
    b_m     = b_i & mask;
    b_eff   = (sub_i ? ~b_m : b_m) & mask;
    cin_eff = sub_i ? ~cin_i : cin_i;
    raw     = {1'b0, a_m} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
    sum_o   = raw[W-1:0] & mask;
    cout    = narrow_i ? raw[NW] : raw[W];
    c_half  = a_m[HB] ^ b_eff[HB] ^ raw[HB];
    carry_o = cout ^ sub_i;
    aux_o   = c_half ^ sub_i;
    a_top   = narrow_i ? a_m[NMSB]   : a_m[MSB];
    b_top   = narrow_i ? b_eff[NMSB] : b_eff[MSB];
    s_top   = narrow_i ? raw[NMSB]   : raw[MSB];
    ovf_o   = (a_top == b_top) && (s_top != a_top);
  end
endmodule

// File: rtl/bwalu_logic.sv
module bwalu_logic
  import bwalu_pkg::*;
#(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  input  logic         narrow_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] mask, raw;

  always_comb begin
    mask = narrow_i ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
    unique case (sel_i)
      LG_AND:  raw = a_i & b_i;
      LG_OR:   raw = a_i | b_i;
      LG_XOR:  raw = a_i ^ b_i;
      default: raw = ~a_i;
    endcase
    res_o = raw & mask;
  end
endmodule

// File: rtl/bwalu_status.sv
module bwalu_status #(
  parameter int W     = 16,
  parameter int NW    = 8,
  parameter int PAR_W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         narrow_i,
  output logic         par_o,
  output logic         zro_o,
  output logic         sgn_o
);
  logic [W-1:0] mask;
  logic [PAR_W-1:0] low;

  generate
    if (PAR_W <= W) begin : g_par_direct
      assign low = res_i[PAR_W-1:0];
    end else begin : g_par_pad
      assign low = {{(PAR_W-W){1'b0}}, res_i};
    end
  endgenerate

  always_comb begin
    mask  = narrow_i ? {{(W-NW){1'b0}}, {NW{1'b1}}} : {W{1'b1}};
    par_o = ~(^low);
    zro_o = ((res_i & mask) == '0);
    sgn_o = narrow_i ? res_i[NW-1] : res_i[W-1];
  end
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bwalu_pkg::*;
#(
  parameter int W     = 16,
  parameter int NW    = 8,
  parameter int PAR_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic         in_byte,
  input  logic [W-1:0] in_dst,
  input  logic [W-1:0] in_src,
  input  logic [5:0]   in_flags,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_wr,
  output logic [5:0]   out_flags
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  alu_op_e     op;
  alu_flags_t  fin, fnext;
  flag_class_e fclass;
  logic_sel_e  lg_sel;
  logic [W-1:0] as_a, as_b, as_sum, lg_res, res;
  logic as_sub, as_cin, use_lg, wr;
  logic as_cry, as_aux, as_ovf, st_par, st_zro, st_sgn;

  assign op  = alu_op_e'(in_op);
  assign fin = alu_flags_t'(in_flags);

  // operation decode
  always_comb begin
    as_a   = in_dst;
    as_b   = in_src;
    as_sub = 1'b0;
    as_cin = 1'b0;
    lg_sel = LG_AND;
    use_lg = 1'b0;
    wr     = 1'b0;
    fclass = FC_HOLD;
    case (op)
      OP_ADD:  begin wr = 1'b1; fclass = FC_ARITH; end
      OP_ADC:  begin as_cin = fin.cry; wr = 1'b1; fclass = FC_ARITH; end
      OP_SUB:  begin as_sub = 1'b1; wr = 1'b1; fclass = FC_ARITH; end
      OP_SBB:  begin as_sub = 1'b1; as_cin = fin.cry; wr = 1'b1; fclass = FC_ARITH; end
      OP_CMP:  begin as_sub = 1'b1; fclass = FC_ARITH; end
      OP_INC:  begin as_b = ONE; wr = 1'b1; fclass = FC_KEEPC; end
      OP_DEC:  begin as_b = ONE; as_sub = 1'b1; wr = 1'b1; fclass = FC_KEEPC; end
      OP_NEG:  begin as_a = '0; as_b = in_dst; as_sub = 1'b1; wr = 1'b1; fclass = FC_ARITH; end
      OP_AND:  begin use_lg = 1'b1; lg_sel = LG_AND; wr = 1'b1; fclass = FC_LOGIC; end
      OP_OR:   begin use_lg = 1'b1; lg_sel = LG_OR;  wr = 1'b1; fclass = FC_LOGIC; end
      OP_XOR:  begin use_lg = 1'b1; lg_sel = LG_XOR; wr = 1'b1; fclass = FC_LOGIC; end
      OP_TEST: begin use_lg = 1'b1; lg_sel = LG_AND; fclass = FC_LOGIC; end
      OP_NOT:  begin use_lg = 1'b1; lg_sel = LG_INV; wr = 1'b1; fclass = FC_HOLD; end
      default: ;
    endcase
  end

  bwalu_addsub #(.W(W), .NW(NW)) u_addsub (
    .a_i(as_a), .b_i(as_b), .sub_i(as_sub), .cin_i(as_cin), .narrow_i(in_byte),
    .sum_o(as_sum), .carry_o(as_cry), .aux_o(as_aux), .ovf_o(as_ovf)
  );

  bwalu_logic #(.W(W), .NW(NW)) u_logic (
    .a_i(in_dst), .b_i(in_src), .sel_i(lg_sel), .narrow_i(in_byte), .res_o(lg_res)
  );

  assign res = use_lg ? lg_res : as_sum;

  bwalu_status #(.W(W), .NW(NW), .PAR_W(PAR_W)) u_status (
    .res_i(res), .narrow_i(in_byte), .par_o(st_par), .zro_o(st_zro), .sgn_o(st_sgn)
  );

  // flag merge per class
  always_comb begin
    fnext = fin;
    unique case (fclass)
      FC_ARITH: begin
        fnext.cry = as_cry; fnext.aux = as_aux; fnext.ovf = as_ovf;
        fnext.par = st_par; fnext.zro = st_zro; fnext.sgn = st_sgn;
      end
      FC_KEEPC: begin
        fnext.aux = as_aux; fnext.ovf = as_ovf;
        fnext.par = st_par; fnext.zro = st_zro; fnext.sgn = st_sgn;
      end
      FC_LOGIC: begin
        fnext.cry = 1'b0; fnext.ovf = 1'b0;
        fnext.par = st_par; fnext.zro = st_zro; fnext.sgn = st_sgn;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wr     <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else begin
      out_valid <= in_valid;
      out_wr    <= in_valid & wr;
      if (in_valid) begin
        out_result <= res;
        out_flags  <= fnext;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_wr_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid);

  assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte) |=> (out_result[W-1:NW] == '0));

  assert_incdec_keep_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_INC || op == OP_DEC)) |=> (out_flags[0] == $past(in_flags[0])));

  assert_logic_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (!out_flags[0] && !out_flags[5] && out_flags[2] == $past(in_flags[2])));

  assert_invert_holds_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NOT) |=> (out_flags == $past(in_flags)));

  assert_neg_carry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NEG)
      |=> (out_flags[0] == $past(in_byte ? (in_dst[NW-1:0] != '0) : (in_dst != '0))));

  assert_flag_only_no_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_CMP || op == OP_TEST)) |=> !out_wr);

  assert_reserved_inert_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op > 4'd12) |=> (!out_wr && out_flags == $past(in_flags)));

endmodule

// File: tb/bw_alu_tb.sv
module bw_alu_tb;
  localparam logic [3:0] ADD = 4'd0, ADC = 4'd1, SUB = 4'd2, SBB = 4'd3,
                         INC = 4'd4, DEC = 4'd5, AND = 4'd6, OR = 4'd7,
                         XOR = 4'd8, NOT = 4'd9, NEG = 4'd10, CMP = 4'd11,
                         TST = 4'd12;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n, in_valid, in_byte;
  logic [3:0]  in_op;
  logic [15:0] in_dst, in_src;
  logic [5:0]  in_flags;
  logic        out_valid, out_wr;
  logic [15:0] out_result;
  logic [5:0]  out_flags;

  int n_chk = 0;
  int n_fail = 0;

  bw_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_byte(in_byte),
    .in_dst(in_dst), .in_src(in_src), .in_flags(in_flags), .out_valid(out_valid),
    .out_result(out_result), .out_wr(out_wr), .out_flags(out_flags)
  );

  task automatic expect_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] op, logic byt, logic [15:0] d, logic [15:0] s, logic [5:0] f);
    in_op = op; in_byte = byt; in_dst = d; in_src = s; in_flags = f; in_valid = 1'b1;
  endtask

  task automatic issue(logic [3:0] op, logic byt, logic [15:0] d, logic [15:0] s, logic [5:0] f);
    @(negedge clk);
    drive(op, byt, d, s, f);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // flags layout {ovf,sgn,zro,aux,par,cry}
  task automatic look(string tag, logic [15:0] r, logic w, logic [5:0] f, bit chk_res);
    expect_eq({tag, " valid"}, int'(out_valid), 1);
    if (chk_res) expect_eq({tag, " result"}, int'(out_result), int'(r));
    expect_eq({tag, " wr"}, int'(out_wr), int'(w));
    expect_eq({tag, " flags"}, int'(out_flags), int'(f));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(ADD, 1'b0, 16'h0, 16'h0, 6'h0); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    expect_eq("R1 valid", int'(out_valid), 0);
    expect_eq("R1 wr", int'(out_wr), 0);
    expect_eq("R1 result", int'(out_result), 0);
    expect_eq("R1 flags", int'(out_flags), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_add;
    issue(ADD, 1'b1, 16'h0088, 16'h0049, 6'b000000);
    look("R4 R6 R8 add 88+49", 16'h00D1, 1'b1, 6'b010110, 1'b1);
    issue(ADD, 1'b1, 16'h00FF, 16'h0001, 6'b000000);
    look("R3 R4 add byte wrap", 16'h0000, 1'b1, 6'b001111, 1'b1);
    issue(ADD, 1'b1, 16'h007F, 16'h0001, 6'b000000);
    look("R7 add byte overflow", 16'h0080, 1'b1, 6'b110100, 1'b1);
    issue(ADD, 1'b0, 16'h7FFF, 16'h0001, 6'b000000);
    look("R3 R7 R8 add word overflow", 16'h8000, 1'b1, 6'b110110, 1'b1);
    issue(ADC, 1'b0, 16'hFFFF, 16'h0000, 6'b000001);
    look("R4 adc word", 16'h0000, 1'b1, 6'b001111, 1'b1);
    issue(ADD, 1'b1, 16'hAB10, 16'hCD20, 6'b000000);
    look("R3 byte ignores upper", 16'h0030, 1'b1, 6'b000010, 1'b1);
  endtask

  task automatic t_sub;
    issue(SUB, 1'b1, 16'h0086, 16'h0057, 6'b000000);
    look("R5 R6 R7 sub byte", 16'h002F, 1'b1, 6'b100100, 1'b1);
    issue(SBB, 1'b0, 16'h0000, 16'h0000, 6'b000001);
    look("R5 sbb word", 16'hFFFF, 1'b1, 6'b010111, 1'b1);
  endtask

  task automatic t_incdec;
    issue(INC, 1'b1, 16'h00FF, 16'h1234, 6'b000000);
    look("R9 inc byte wrap", 16'h0000, 1'b1, 6'b001110, 1'b1);
    issue(INC, 1'b0, 16'h7FFF, 16'h0000, 6'b000001);
    look("R9 inc word keeps carry", 16'h8000, 1'b1, 6'b110111, 1'b1);
    issue(DEC, 1'b1, 16'h0000, 16'h0000, 6'b000000);
    look("R9 dec byte", 16'h00FF, 1'b1, 6'b010110, 1'b1);
  endtask

  task automatic t_logic;
    issue(AND, 1'b0, 16'hF0F0, 16'h0FFF, 6'b100101);
    look("R10 and word", 16'h00F0, 1'b1, 6'b000110, 1'b1);
    issue(OR, 1'b1, 16'h0080, 16'h0001, 6'b000000);
    look("R10 or byte", 16'h0081, 1'b1, 6'b010010, 1'b1);
    issue(XOR, 1'b0, 16'h5A5A, 16'h5A5A, 6'b111111);
    look("R10 xor word", 16'h0000, 1'b1, 6'b001110, 1'b1);
  endtask

  task automatic t_not;
    issue(NOT, 1'b0, 16'h00FF, 16'h0000, 6'b101010);
    look("R11 invert word", 16'hFF00, 1'b1, 6'b101010, 1'b1);
    issue(NOT, 1'b1, 16'h120F, 16'hFFFF, 6'b010101);
    look("R11 R3 invert byte", 16'h00F0, 1'b1, 6'b010101, 1'b1);
  endtask

  task automatic t_neg;
    issue(NEG, 1'b1, 16'h0001, 16'h5555, 6'b000000);
    look("R12 neg 1", 16'h00FF, 1'b1, 6'b010111, 1'b1);
    issue(NEG, 1'b1, 16'h0000, 16'h5555, 6'b000001);
    look("R12 neg zero", 16'h0000, 1'b1, 6'b001010, 1'b1);
    issue(NEG, 1'b1, 16'h0080, 16'h0000, 6'b000000);
    look("R12 R7 neg 80", 16'h0080, 1'b1, 6'b110001, 1'b1);
  endtask

  task automatic t_flag_only;
    issue(CMP, 1'b0, 16'h1234, 16'h1234, 6'b000000);
    look("R13 cmp equal", 16'h0, 1'b0, 6'b001010, 1'b0);
    issue(CMP, 1'b1, 16'h0001, 16'h0002, 6'b000000);
    look("R13 cmp below", 16'h0, 1'b0, 6'b010111, 1'b0);
    issue(TST, 1'b1, 16'h00F0, 16'h003C, 6'b000101);
    look("R13 test byte", 16'h0, 1'b0, 6'b000110, 1'b0);
  endtask

  task automatic t_reserved;
    issue(4'd13, 1'b0, 16'h1111, 16'h2222, 6'b011001);
    look("R14 reserved 13", 16'h0, 1'b0, 6'b011001, 1'b0);
    issue(4'd15, 1'b1, 16'h00FF, 16'h00FF, 6'b100110);
    look("R14 reserved 15", 16'h0, 1'b0, 6'b100110, 1'b0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    drive(ADD, 1'b1, 16'h0001, 16'h0002, 6'b000000);
    @(negedge clk);
    drive(SUB, 1'b0, 16'h0003, 16'h0005, 6'b000000);
    look("R2 stream first", 16'h0003, 1'b1, 6'b000010, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    look("R2 stream second", 16'hFFFE, 1'b1, 6'b010101, 1'b1);
    @(negedge clk);
    expect_eq("R2 valid drops", int'(out_valid), 0);
    expect_eq("R2 wr drops", int'(out_wr), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_incdec();
    t_logic();
    t_not();
    t_neg();
    t_flag_only();
    t_reserved();
    t_stream();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule